// File: doc/BRIEF.md
# Opcode-Stream Video Level Generator

This block produces a video waveform from a program held in memory. The program is not a bitmap. Once enabled, the block reads 20-bit words through a memory request port. The system arbiter serves that port ahead of the processor. The block splits each word into four 5-bit video opcodes and runs them in order, one opcode per pixel clock.

Each opcode that runs gives one output sample. A sample is a level code: black, sync, colour-burst phase, or a pixel with a 4-bit colour. A valid strobe comes with each sample. Some control opcodes act on the program flow instead:
- one redirects fetching to a new address;
- one abandons the rest of the current word;
- one marks a memory-refresh slot.

These control opcodes are honoured only in fixed slots of the word. In any other slot they give a black sample.

A later stage turns the level code into an analogue signal. That stage is outside this block. While the enable input is low the block is idle. On each enable the block starts fetching from the start address.

Top module: `vsg_engine`

## Requirements
- R1: The slots of a word run in order from the most significant 5 bits (slot 0, bits 19:15) to the least significant (slot 3, bits 4:0). Each slot that runs gives one sample with `out_valid` high. Samples come out in program order, with no sample lost or repeated.
- R2: An opcode with bit 4 clear and a non-zero value gives kind 3 (pixel). Its colour is the low four bits: bit 3 intensity, bit 2 green, bit 1 red, bit 0 blue.
- R3: Opcode 0x00 gives kind 0 (black) with colour 0. So does any opcode with bit 4 set that has no defined meaning.
- R4: Opcode 0x17 gives kind 1 (sync) with `out_sync` high. Opcode 0x15 gives kind 2 (burst) with `out_sync` low. Both work in any slot and give colour 0.
- R5: Opcode 0x13 in slot 0 gives one black sample, and the remaining slots of that word are dropped. In any other slot it is a plain black sample.
- R6: Opcode 0x1F in slot 2 gives one black sample with `out_refresh` high. In any other slot it is a plain black sample with `out_refresh` low.
- R7: Opcode 0x18 in slot 0 gives no sample. The low 20 bits of the word that follows it in memory become the next fetch address, and the rest of the word is dropped. In any other slot it is a plain black sample.
- R8: While `enable` is low, `mem_req` is low and the outputs are reset: valid 0, kind 0, colour 0, sync 0, refresh 0, underrun 0. The first request after enable is raised is to `start_addr`.
- R9: After the first sample since enable, any clock with no sample raises `underrun`. In that clock, kind, colour and sync keep the values of the last sample.
- R10: `mem_req` stays high, with `mem_addr` unchanged, until `mem_ack` is sampled high. The word is taken from `mem_rdata` in that same clock. Fetch addresses go up by one per word, except where a jump redirects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds the block idle |
| start_addr | input | 20 | First fetch address after enable |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | 20 | Fetch word address |
| mem_ack | input | 1 | Fetch grant with data valid |
| mem_rdata | input | 20 | Fetched word |
| out_valid | output | 1 | A sample was produced this clock |
| out_kind | output | 2 | 0 black, 1 sync, 2 burst, 3 pixel |
| out_color | output | 4 | Pixel colour (intensity, green, red, blue) |
| out_sync | output | 1 | Sync level active |
| out_refresh | output | 1 | Refresh slot marker |
| underrun | output | 1 | No sample was ready this clock |

## Verification
The bench uses the default configuration of four 5-bit slots per 20-bit word. Its program is a 32-word block whose slot-0 opcode takes every one of the 32 values exactly once. The other slots also sweep every value. Every opcode therefore lands both in its allowed slot and in forbidden slots, including a skip word and a jump through a pointer word.

The bench runs this program from three start addresses with memory latencies of 0, 2 and 6 extra clocks. The short latency checks the gap-free sample stream across words. The long latency forces underrun gaps, so the hold behaviour and the request-stability rule are both exercised.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

   typedef enum logic [2:0] {
      C_BLACK,
      C_SYNC,
      C_BURST,
      C_PIXEL,
      C_SKIP,
      C_REFRESH,
      C_JUMP
   } vsg_cls_e;

   localparam logic [1:0] K_BLACK = 2'd0;
   localparam logic [1:0] K_SYNC  = 2'd1;
   localparam logic [1:0] K_BURST = 2'd2;
   localparam logic [1:0] K_PIXEL = 2'd3;

   localparam logic [4:0] OPC_BLACK   = 5'h00;
   localparam logic [4:0] OPC_SYNC    = 5'h17;
   localparam logic [4:0] OPC_BURST   = 5'h15;
   localparam logic [4:0] OPC_SKIP    = 5'h13;
   localparam logic [4:0] OPC_REFRESH = 5'h1F;
   localparam logic [4:0] OPC_JUMP    = 5'h18;

endpackage

// File: rtl/vsg_slot_mux.sv
module vsg_slot_mux #(
   parameter int WORD_W = 20,
   parameter int OP_W   = 5,
   localparam int SLOTS  = WORD_W / OP_W,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SLOT_W-1:0] sel,
   output logic [OP_W-1:0]   op
);

   logic [OP_W-1:0] ops [SLOTS];

   // slot 0 occupies the most significant field
   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign ops[g] = word[WORD_W-1-g*OP_W -: OP_W];
   end

   always_comb begin
      op = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (sel == SLOT_W'(i)) op = ops[i];
      end
   end

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
   import vsg_pkg::*;
#(
   parameter int OP_W = 5
) (
   input  logic [OP_W-1:0] op,
   input  logic            at_first,
   input  logic            at_refresh,
   output vsg_cls_e        cls
);

   always_comb begin
      cls = C_BLACK;
      if (!op[OP_W-1]) begin
         cls = (op == '0) ? C_BLACK : C_PIXEL;
      end else begin
         unique case (op)
            OPC_SYNC:    cls = C_SYNC;
            OPC_BURST:   cls = C_BURST;
            OPC_SKIP:    cls = at_first   ? C_SKIP    : C_BLACK;
            OPC_JUMP:    cls = at_first   ? C_JUMP    : C_BLACK;
            OPC_REFRESH: cls = at_refresh ? C_REFRESH : C_BLACK;
            default:     cls = C_BLACK;
         endcase
      end
   end

endmodule

// File: rtl/vsg_fetch.sv
module vsg_fetch #(
   parameter int WORD_W = 20,
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              consume,
   input  logic              redirect,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              nxt_valid,
   output logic [WORD_W-1:0] nxt_word
);

   logic [ADDR_W-1:0] faddr;
   logic [ADDR_W-1:0] target;

   // the pointer word may be wider than the address space
   if (ADDR_W == WORD_W) begin : g_tgt_full
      assign target = nxt_word;
   end else begin : g_tgt_slice
      assign target = nxt_word[ADDR_W-1:0];
   end

   assign mem_req  = enable && !nxt_valid;
   assign mem_addr = faddr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         faddr     <= '0;
         nxt_valid <= 1'b0;
         nxt_word  <= '0;
      end else if (!enable) begin
         faddr     <= start_addr;
         nxt_valid <= 1'b0;
      end else if (redirect) begin
         faddr     <= target;
         nxt_valid <= 1'b0;
      end else if (mem_req && mem_ack) begin
         nxt_word  <= mem_rdata;
         nxt_valid <= 1'b1;
         faddr     <= faddr + ADDR_W'(1);
      end else if (consume) begin
         nxt_valid <= 1'b0;
      end
   end

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mem_req && !mem_ack) |=> (!enable || (mem_req && $stable(mem_addr))));

   p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mem_req && mem_ack) |=> (!enable || mem_addr == $past(mem_addr) + ADDR_W'(1)));

   p_no_req_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mem_req && mem_ack) |=> !mem_req);

endmodule

// File: rtl/vsg_engine.sv
module vsg_engine
   import vsg_pkg::*;
#(
   parameter int WORD_W       = 20,
   parameter int OP_W         = 5,
   parameter int ADDR_W       = 20,
   parameter int REFRESH_SLOT = 2,
   localparam int SLOTS  = WORD_W / OP_W,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int COL_W  = OP_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              out_valid,
   output logic [1:0]        out_kind,
   output logic [COL_W-1:0]  out_color,
   output logic              out_sync,
   output logic              out_refresh,
   output logic              underrun
);

   // elaboration-time parameter checks
   if (OP_W != 5) begin : g_bad_op
      $error("vsg_engine: opcode width must be 5");
   end
   if (WORD_W % OP_W != 0) begin : g_bad_word
      $error("vsg_engine: word width must be a multiple of the opcode width");
   end
   if (REFRESH_SLOT >= SLOTS || SLOTS < 2) begin : g_bad_slot
      $error("vsg_engine: refresh slot outside the word");
   end
   if (ADDR_W > WORD_W) begin : g_bad_addr
      $error("vsg_engine: address wider than a memory word");
   end

   logic              nxt_valid;
   logic [WORD_W-1:0] nxt_word;
   logic [WORD_W-1:0] cur_word;
   logic              cur_valid;
   logic [SLOT_W-1:0] slot;
   logic              started;
   logic [OP_W-1:0]   op;
   vsg_cls_e          cls;
   logic              exec, last, word_done, jump_go, consume;

   vsg_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .start_addr (start_addr),
      .consume    (consume),
      .redirect   (jump_go),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .nxt_valid  (nxt_valid),
      .nxt_word   (nxt_word)
   );

   vsg_slot_mux #(.WORD_W(WORD_W), .OP_W(OP_W)) u_mux (
      .word (cur_word),
      .sel  (slot),
      .op   (op)
   );

   vsg_decode #(.OP_W(OP_W)) u_dec (
      .op         (op),
      .at_first   (slot == '0),
      .at_refresh (slot == SLOT_W'(REFRESH_SLOT)),
      .cls        (cls)
   );

   always_comb begin
      exec      = cur_valid && (cls != C_JUMP);
      last      = (slot == SLOT_W'(SLOTS - 1));
      word_done = exec && (last || cls == C_SKIP);
      jump_go   = cur_valid && (cls == C_JUMP) && nxt_valid;
      consume   = nxt_valid && (!cur_valid || word_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_word    <= '0;
         cur_valid   <= 1'b0;
         slot        <= '0;
         started     <= 1'b0;
         out_valid   <= 1'b0;
         out_kind    <= K_BLACK;
         out_color   <= '0;
         out_sync    <= 1'b0;
         out_refresh <= 1'b0;
         underrun    <= 1'b0;
      end else if (!enable) begin
         cur_valid   <= 1'b0;
         slot        <= '0;
         started     <= 1'b0;
         out_valid   <= 1'b0;
         out_kind    <= K_BLACK;
         out_color   <= '0;
         out_sync    <= 1'b0;
         out_refresh <= 1'b0;
         underrun    <= 1'b0;
      end else begin
         if (consume) begin
            cur_word  <= nxt_word;
            cur_valid <= 1'b1;
            slot      <= '0;
         end else if (word_done || jump_go) begin
            cur_valid <= 1'b0;
            slot      <= '0;
         end else if (exec) begin
            slot <= slot + SLOT_W'(1);
         end
         out_valid   <= exec;
         out_refresh <= exec && (cls == C_REFRESH);
         underrun    <= started && !exec;
         started     <= started || exec;
         if (exec) begin
            out_color <= '0;
            out_sync  <= 1'b0;
            unique case (cls)
               C_SYNC: begin
                  out_kind <= K_SYNC;
                  out_sync <= 1'b1;
               end
               C_BURST: out_kind <= K_BURST;
               C_PIXEL: begin
                  out_kind  <= K_PIXEL;
                  out_color <= op[COL_W-1:0];
               end
               default: out_kind <= K_BLACK;
            endcase
         end
      end
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> ($stable(out_kind) && $stable(out_color) && $stable(out_sync)));

   p_gap_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && underrun));

   p_refresh_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_refresh |-> (out_valid && out_kind == K_BLACK));

   p_sync_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_sync |-> (out_valid || underrun));

   p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!out_valid && !underrun && !out_refresh));

   p_jump_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && jump_go) |=> !out_valid);

endmodule

// File: tb/vsg_engine_bench.sv
module vsg_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [19:0] start_addr = '0;
   logic        mem_req;
   logic [19:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [19:0] mem_rdata = '0;
   logic        out_valid;
   logic [1:0]  out_kind;
   logic [3:0]  out_color;
   logic        out_sync;
   logic        out_refresh;
   logic        underrun;

   int checks = 0;
   int errors = 0;
   int lat_sel = 0;
   int wait_cnt = 0;

   logic [19:0] mem [64];
   int    ek [400];
   int    ec [400];
   bit    er [400];
   string etag [400];
   int    nexp;

   always #4 clk = ~clk;

   vsg_engine u_vsg_engine (
      .clk (clk), .rst_n (rst_n), .enable (enable), .start_addr (start_addr),
      .mem_req (mem_req), .mem_addr (mem_addr), .mem_ack (mem_ack), .mem_rdata (mem_rdata),
      .out_valid (out_valid), .out_kind (out_kind), .out_color (out_color),
      .out_sync (out_sync), .out_refresh (out_refresh), .underrun (underrun)
   );

   // memory model: grants after lat_sel extra clocks of an open request
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         if (wait_cnt >= lat_sel) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[5:0]];
            wait_cnt  <= 0;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
         if (!mem_req) wait_cnt <= 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", tag, what);
      end
   endtask

   task automatic emit(inout int n, input int nitems, input int k, input int c,
                       input bit r, input string tag);
      if (n < nitems) begin
         ek[n] = k; ec[n] = c; er[n] = r; etag[n] = tag;
         n++;
      end
   endtask

   // expected sample stream, interpreted from the requirements
   task automatic build_exp(input int start, input int nitems);
      int pc;
      int n;
      logic [19:0] w;
      logic [4:0] op;
      bit after_jump;
      pc = start; n = 0; after_jump = 0;
      while (n < nitems) begin
         w = mem[pc % 64];
         pc = pc + 1;
         for (int s = 0; s < 4; s++) begin
            op = w[19-5*s -: 5];
            if (s == 0 && op == 5'h18) begin
               pc = int'(mem[pc % 64]);
               after_jump = 1;
               break;
            end
            if (!op[4] && op != 5'h00)
               emit(n, nitems, 3, int'(op[3:0]), 0, after_jump ? "R7" : (s == 3 ? "R1" : "R2"));
            else if (op == 5'h17) emit(n, nitems, 1, 0, 0, "R4");
            else if (op == 5'h15) emit(n, nitems, 2, 0, 0, "R4");
            else if (op == 5'h13) emit(n, nitems, 0, 0, 0, "R5");
            else if (op == 5'h18) emit(n, nitems, 0, 0, 0, "R7");
            else if (op == 5'h1F) emit(n, nitems, 0, 0, s == 2, "R6");
            else emit(n, nitems, 0, 0, 0, after_jump ? "R7" : "R3");
            after_jump = 0;
            if (s == 0 && op == 5'h13) break;
         end
      end
      nexp = n;
   endtask

   task automatic check_idle(input string when);
      chk(!mem_req, "R8", $sformatf("%s mem_req=%0b expected 0", when, mem_req));
      chk(!out_valid && !underrun && !out_sync && !out_refresh && out_kind == 2'd0 && out_color == 4'd0,
          "R8", $sformatf("%s outputs v=%0b u=%0b k=%0d c=%0h, expected all zero",
                          when, out_valid, underrun, out_kind, out_color));
   endtask

   task automatic run_case(input int start, input int lat, input int nitems, input bit need_gap);
      int idx;
      int guard;
      bit seen, gap_seen, preq, pack;
      logic [19:0] paddr;
      logic [1:0] pk;
      logic [3:0] pc4;
      logic ps;
      build_exp(start, nitems);
      lat_sel = lat;
      start_addr = 20'(start);
      @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      chk(mem_req && mem_addr == 20'(start), "R8",
          $sformatf("first fetch req=%0b addr=%0d, expected 1 and %0d", mem_req, mem_addr, start));
      idx = 0; guard = 0; seen = 0; gap_seen = 0; preq = 0; pack = 0; paddr = '0;
      pk = '0; pc4 = '0; ps = 0;
      while (idx < nexp && guard < 6000) begin
         @(negedge clk);
         guard++;
         if (preq && !pack)
            chk(mem_req && mem_addr == paddr, "R10",
                $sformatf("request dropped or moved: req=%0b addr=%0d, expected 1 and %0d",
                          mem_req, mem_addr, paddr));
         preq = mem_req; pack = mem_ack; paddr = mem_addr;
         if (out_valid) begin
            chk(int'(out_kind) == ek[idx] && int'(out_color) == ec[idx] && out_refresh == er[idx]
                && out_sync == (ek[idx] == 1), etag[idx],
                $sformatf("item %0d kind=%0d col=%0h ref=%0b sync=%0b, expected kind=%0d col=%0h ref=%0b",
                          idx, out_kind, out_color, out_refresh, out_sync, ek[idx], ec[idx], er[idx]));
            pk = out_kind; pc4 = out_color; ps = out_sync;
            idx++;
            seen = 1;
         end else if (seen) begin
            gap_seen = 1;
            chk(underrun && out_kind == pk && out_color == pc4 && out_sync == ps, "R9",
                $sformatf("gap u=%0b kind=%0d col=%0h, expected 1 %0d %0h", underrun, out_kind,
                          out_color, pk, pc4));
         end else begin
            chk(!underrun, "R9", $sformatf("underrun=%0b before first sample, expected 0", underrun));
         end
      end
      chk(idx == nexp, "R1", $sformatf("samples seen %0d, expected %0d", idx, nexp));
      if (need_gap) chk(gap_seen, "R9", "slow memory gave no underrun gap, expected one");
      enable = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_idle("after disable");
   endtask

   initial begin
      for (int k = 0; k < 64; k++) mem[k] = '0;
      for (int k = 0; k < 32; k++)
         mem[k] = {5'((k + 25) % 32), 5'((k + 7) % 32), 5'((k + 13) % 32), 5'((k + 21) % 32)};
      mem[32] = 20'd40;
      for (int j = 0; j < 8; j++) mem[40 + j] = {5'h17, 5'h15, 5'h1F, 5'(j + 1)};
      mem[48] = {5'h18, 15'd0};
      mem[49] = 20'd0;

      repeat (3) @(negedge clk);
      check_idle("in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_idle("disabled");

      run_case(0, 0, 300, 0);
      run_case(40, 6, 60, 1);
      run_case(26, 2, 80, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule